// File: doc/BRIEF.md
# GPIO Pin Bank with Packed Per-Pin Configuration

A sixteen-pin general-purpose I/O bank controlled through a small word-addressed register bus. Every pin owns a 4-bit configuration field. The fields for pins 0..7 are packed into the first configuration word and those for pins 8..15 into the second. Each field is decoded into pad controls: drive enable, open-drain behaviour, selection between the output latch and a peripheral signal, pull enable, and analog isolation. The pad controls are registered before they leave the block.

An output latch supplies the value for ordinary outputs. Two write-only words change latch bits without a read-modify-write. For a pin configured as a pulled input, the latch bit selects the pull direction. Writing the latch therefore also moves that pin's pull between up and down. The pad inputs pass through a two-flop synchroniser and can be read back through an input word. A pin in analog mode reads as zero there.

Word addresses on `bus_addr`: 0 is the low configuration word, 1 the high configuration word, 2 the input word, 3 the output latch, 4 the set/clear word and 5 the clear word. Read data is registered.

Top module: `gpio_pinbank`

## Requirements
- R1: After reset, every configuration field holds 4, the output latch is 0, and `pad_oe`, `pad_pu` and `pad_pd` are all 0.
- R2: The field of pin n sits at bits [4*(n mod 8)+3 : 4*(n mod 8)] of word 0 for n < 8, and of word 1 for n >= 8. A written configuration word reads back unchanged.
- R3: Field values 2 and 3 select push-pull output: the pin's `pad_oe` is 1 and its `pad_out` equals its latch bit.
- R4: Field value 7 selects open-drain output: `pad_out` is 0 and `pad_oe` is the inverse of the latch bit.
- R5: Field value 0xB drives `periph_out` push-pull (`pad_oe` 1, `pad_out` = `periph_out`). Field value 0xF drives it open-drain (`pad_oe` = not `periph_out`, `pad_out` 0). The latch bit has no effect in either mode.
- R6: Field value 8 selects a pulled input. `pad_pu` equals the latch bit, `pad_pd` is its inverse, and `pad_oe` is 0. A later latch write moves the pull direction.
- R7: Field value 4 (floating input) and field value 0 (analog input) drive nothing and enable no pull. An analog pin reads as 0 in the input word even when its pad is high.
- R8: The input word (address 2) shows `pad_in` through two synchronising flops. A change of `pad_in` made between edges is still absent from read data after the second rising edge and present after the third.
- R9: Writing address 4 sets the latch bits named in wdata[15:0] and clears the bits named in wdata[31:16]. Set wins when a bit is named in both halves, and bits named in neither half are unchanged.
- R10: Writing address 5 clears the latch bits named in wdata[15:0] and leaves the others unchanged.
- R11: Addresses 4 and 5 read as zero.
- R12: A register write takes effect at the write edge. The pad outputs follow one rising edge later, and read data appears one rising edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| periph_out | input | 16 | Per-pin peripheral drive value for alternate modes |
| pad_in | input | 16 | Asynchronous pad input levels |
| pad_out | output | 16 | Pad output value |
| pad_oe | output | 16 | Pad output enable |
| pad_pu | output | 16 | Pull-up enable |
| pad_pd | output | 16 | Pull-down enable |

## Verification
Every result of the bank has a fixed latency:
- A register write is visible in read data on the edge after the read address is set.
- Pad outputs change one rising edge after the write or `periph_out` change that causes them.
- A `pad_in` change reaches read data on the third rising edge.

The bench drives stimulus on falling edges and counts exactly that many rising edges before sampling on the next falling edge. For the push-pull latency and the synchroniser it also samples one edge early, to show the old value still present.

// File: rtl/gpio_pinbank_pkg.sv
package gpio_pinbank_pkg;

  localparam int FIELD_W = 4;
  localparam logic [FIELD_W-1:0] CFG_RESET = 4'h4;

  typedef struct packed {
    logic drive;
    logic open_drain;
    logic alt_sel;
    logic pull_en;
    logic analog;
  } pin_ctl_t;

  // Low two bits: output speed, 00 = input. Upper two bits: sub-mode.
  function automatic pin_ctl_t decode_field(input logic [FIELD_W-1:0] f);
    pin_ctl_t c;
    c = '0;
    if (f[1:0] == 2'b00) begin
      case (f[3:2])
        2'b00:   c.analog  = 1'b1;
        2'b10:   c.pull_en = 1'b1;
        default: c = '0;
      endcase
    end else begin
      c.drive      = 1'b1;
      c.open_drain = f[2];
      c.alt_sel    = f[3];
    end
    return c;
  endfunction

endpackage

// File: rtl/gpio_pinbank_insync.sv
module gpio_pinbank_insync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
  import gpio_pinbank_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [FIELD_W-1:0] cfg_field,
  input  logic               latch_bit,
  input  logic               periph_bit,
  output logic               pad_out,
  output logic               pad_oe,
  output logic               pad_pu,
  output logic               pad_pd,
  output logic               analog_mode
);

  pin_ctl_t ctl;
  logic     value;

  assign ctl         = decode_field(cfg_field);
  assign value       = ctl.alt_sel ? periph_bit : latch_bit;
  assign analog_mode = ctl.analog;

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= 1'b0;
      pad_oe  <= 1'b0;
      pad_pu  <= 1'b0;
      pad_pd  <= 1'b0;
    end else begin
      pad_out <= ctl.drive && !ctl.open_drain && value;
      pad_oe  <= ctl.drive && (!ctl.open_drain || !value);
      pad_pu  <= ctl.pull_en && latch_bit;
      pad_pd  <= ctl.pull_en && !latch_bit;
    end
  end

  AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(pad_pu && pad_pd)); // R6

  AST_DRIVE_NO_PULL: assert property (@(posedge clk) disable iff (rst)
    pad_oe |-> !(pad_pu || pad_pd)); // R7

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
    (pad_out |-> pad_oe)); // R4

endmodule

// File: rtl/gpio_pinbank_regs.sv
module gpio_pinbank_regs
  import gpio_pinbank_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_we,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic [NUM_PINS-1:0]         in_data,
  output logic [NUM_PINS*FIELD_W-1:0] cfg_flat,
  output logic [NUM_PINS-1:0]         latch_q
);

  localparam int FIELDS_PER_WORD = DATA_W / FIELD_W;
  localparam int NUM_BANKS       = NUM_PINS / FIELDS_PER_WORD;
  localparam int A_IN            = NUM_BANKS;
  localparam int A_LATCH         = NUM_BANKS + 1;
  localparam int A_SETCLR        = NUM_BANKS + 2;
  localparam int A_CLR           = NUM_BANKS + 3;
  localparam logic [DATA_W-1:0] BANK_RESET = {FIELDS_PER_WORD{CFG_RESET}};

  logic [DATA_W-1:0]   bank_q [NUM_BANKS];
  logic [NUM_PINS-1:0] latch_d;
  logic [DATA_W-1:0]   rdata_d;
  logic [NUM_PINS-1:0] set_mask;
  logic [NUM_PINS-1:0] clr_mask;

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      always_ff @(posedge clk) begin
        if (rst) begin
          bank_q[b] <= BANK_RESET;
        end else if (bus_we && bus_addr == ADDR_W'(b)) begin
          bank_q[b] <= bus_wdata;
        end
      end
      assign cfg_flat[b*DATA_W +: DATA_W] = bank_q[b];
    end
  endgenerate

  assign set_mask = bus_wdata[NUM_PINS-1:0];
  assign clr_mask = bus_wdata[NUM_PINS +: NUM_PINS];

  always_comb begin
    latch_d = latch_q;
    if (bus_we) begin
      if (bus_addr == ADDR_W'(A_LATCH)) begin
        latch_d = bus_wdata[NUM_PINS-1:0];
      end else if (bus_addr == ADDR_W'(A_SETCLR)) begin
        latch_d = (latch_q & ~clr_mask) | set_mask;
      end else if (bus_addr == ADDR_W'(A_CLR)) begin
        latch_d = latch_q & ~set_mask;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) latch_q <= '0;
    else     latch_q <= latch_d;
  end

  always_comb begin
    rdata_d = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bus_addr == ADDR_W'(b)) rdata_d = bank_q[b];
    end
    if (bus_addr == ADDR_W'(A_IN))    rdata_d = DATA_W'(in_data);
    if (bus_addr == ADDR_W'(A_LATCH)) rdata_d = DATA_W'(latch_q);
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rdata_d;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(A_SETCLR)) |=>
      ((latch_q & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0]))); // R9

  AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(A_CLR)) |=>
      ((latch_q & $past(bus_wdata[NUM_PINS-1:0])) == '0)); // R10

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> $stable(latch_q)); // R12

  AST_STROBE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(A_SETCLR) || bus_addr == ADDR_W'(A_CLR)) |=> (bus_rdata == '0)); // R11

endmodule

// File: rtl/gpio_pinbank.sv
module gpio_pinbank
  import gpio_pinbank_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] periph_out,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_pu,
  output logic [NUM_PINS-1:0] pad_pd
);

  logic [NUM_PINS*FIELD_W-1:0] cfg_flat;
  logic [NUM_PINS-1:0]         latch_q;
  logic [NUM_PINS-1:0]         sync_q;
  logic [NUM_PINS-1:0]         analog_vec;
  logic [NUM_PINS-1:0]         in_data;

  gpio_pinbank_regs #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .in_data   (in_data),
    .cfg_flat  (cfg_flat),
    .latch_q   (latch_q)
  );

  gpio_pinbank_insync #(
    .WIDTH (NUM_PINS)
  ) u_insync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pad_in),
    .sync_out (sync_q)
  );

  assign in_data = sync_q & ~analog_vec;

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      gpio_pin_drive u_pin (
        .clk         (clk),
        .rst         (rst),
        .cfg_field   (cfg_flat[p*FIELD_W +: FIELD_W]),
        .latch_bit   (latch_q[p]),
        .periph_bit  (periph_out[p]),
        .pad_out     (pad_out[p]),
        .pad_oe      (pad_oe[p]),
        .pad_pu      (pad_pu[p]),
        .pad_pd      (pad_pd[p]),
        .analog_mode (analog_vec[p])
      );
    end
  endgenerate

endmodule

// File: tb/gpio_pinbank_bench.sv
module gpio_pinbank_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_CFG0 = 3'd0, A_CFG1 = 3'd1, A_IN = 3'd2,
                         A_LATCH = 3'd3, A_SETCLR = 3'd4, A_CLR = 3'd5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] periph_out = '0;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_out, pad_oe, pad_pu, pad_pd;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] cfg_sh [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_pinbank u_gpio_pinbank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_out(periph_out),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_field(input int pin, input logic [3:0] v);
    int w = pin / 8;
    cfg_sh[w][(pin % 8)*4 +: 4] = v;
    wr(w[2:0], cfg_sh[w]);
    settle();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_CFG0, d); chk("R1 cfg0", d, 32'h4444_4444);
    rd(A_CFG1, d); chk("R1 cfg1", d, 32'h4444_4444);
    rd(A_LATCH, d); chk("R1 latch", d, 32'h0);
    chk("R1 oe", {16'h0, pad_oe}, 32'h0);
    chk("R1 pu", {16'h0, pad_pu}, 32'h0);
    chk("R1 pd", {16'h0, pad_pd}, 32'h0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    set_field(9, 4'h3);
    rd(A_CFG1, d); chk("R2 cfg1 pin9 field", d, 32'h4444_4434);
    rd(A_CFG0, d); chk("R2 cfg0 untouched", d, 32'h4444_4444);
    wr(A_LATCH, 32'h0000_0200); settle();
    chk("R2 pin9 oe", {16'h0, pad_oe}, 32'h0000_0200);
    chk("R2 pin9 out", {16'h0, pad_out}, 32'h0000_0200);
  endtask

  task automatic t_pushpull();
    set_field(1, 4'h2);
    chk("R3 pin1 oe", {16'h0, pad_oe}, 32'h0000_0202);
    wr(A_LATCH, 32'h0000_0002);
    chk("R12 pads not yet updated", {16'h0, pad_out}, 32'h0000_0200);
    settle();
    chk("R12 pads updated one edge later", {16'h0, pad_out}, 32'h0000_0002);
    chk("R3 push-pull out", {16'h0, pad_out}, 32'h0000_0002);
    wr(A_LATCH, 32'h0); settle();
    chk("R3 push-pull low", {16'h0, pad_out}, 32'h0);
    chk("R3 push-pull oe held", {16'h0, pad_oe}, 32'h0000_0202);
  endtask

  task automatic t_opendrain();
    set_field(3, 4'h7);
    chk("R4 od latch0 oe", {31'h0, pad_oe[3]}, 32'h1);
    chk("R4 od latch0 out", {31'h0, pad_out[3]}, 32'h0);
    wr(A_LATCH, 32'h0000_0008); settle();
    chk("R4 od latch1 oe", {31'h0, pad_oe[3]}, 32'h0);
    chk("R4 od latch1 out", {31'h0, pad_out[3]}, 32'h0);
    wr(A_LATCH, 32'h0); settle();
  endtask

  task automatic t_alt();
    set_field(12, 4'hB);
    set_field(13, 4'hF);
    wr(A_LATCH, 32'h0000_3000);
    @(negedge clk); periph_out = 16'h0000;
    settle();
    chk("R5 alt periph0 out", {30'h0, pad_out[13:12]}, 32'h0);
    chk("R5 alt periph0 oe", {30'h0, pad_oe[13:12]}, 32'h3);
    @(negedge clk); periph_out = 16'h3000;
    settle();
    chk("R5 alt periph1 out", {30'h0, pad_out[13:12]}, 32'h1);
    chk("R5 alt periph1 oe", {30'h0, pad_oe[13:12]}, 32'h1);
    wr(A_LATCH, 32'h0); settle();
    chk("R5 latch ignored", {30'h0, pad_out[13:12]}, 32'h1);
  endtask

  task automatic t_pull();
    set_field(5, 4'h8);
    chk("R6 pull-down when latch0", {30'h0, pad_pu[5], pad_pd[5]}, 32'h1);
    chk("R6 pulled pin undriven", {31'h0, pad_oe[5]}, 32'h0);
    wr(A_SETCLR, 32'h0000_0020); settle();
    chk("R6 pull-up after latch set", {30'h0, pad_pu[5], pad_pd[5]}, 32'h2);
    wr(A_CLR, 32'h0000_0020); settle();
  endtask

  task automatic t_float_analog();
    logic [31:0] d;
    set_field(7, 4'h0);
    @(negedge clk); pad_in = 16'h00C0;
    repeat (4) settle();
    rd(A_IN, d); chk("R7 analog reads 0, floating reads pad", d & 32'hC0, 32'h40);
    chk("R7 no drive", {30'h0, pad_oe[7:6]}, 32'h0);
    chk("R7 no pulls", {28'h0, pad_pu[7:6], pad_pd[7:6]}, 32'h0);
  endtask

  task automatic t_sync();
    @(negedge clk); pad_in = 16'h0000; bus_addr = A_IN;
    repeat (4) settle();
    chk("R8 input idle", bus_rdata, 32'h0);
    pad_in = 16'h0A01;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R8 not visible after two edges", bus_rdata, 32'h0);
    settle();
    chk("R8 visible after three edges", bus_rdata, 32'h0000_0A01);
  endtask

  task automatic t_setclr();
    logic [31:0] d;
    wr(A_LATCH, 32'h0000_00F0);
    wr(A_SETCLR, 32'h0111_0101);
    rd(A_LATCH, d); chk("R9 set wins, others kept", d, 32'h0000_01E1);
  endtask

  task automatic t_clr();
    logic [31:0] d;
    wr(A_CLR, 32'h0000_00C0);
    rd(A_LATCH, d); chk("R10 clear", d, 32'h0000_0121);
  endtask

  task automatic t_readzero();
    logic [31:0] d;
    rd(A_SETCLR, d); chk("R11 setclr reads zero", d, 32'h0);
    rd(A_CLR, d);    chk("R11 clear reads zero", d, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    cfg_sh[0] = 32'h4444_4444;
    cfg_sh[1] = 32'h4444_4444;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_layout();
    t_pushpull();
    t_opendrain();
    t_alt();
    t_pull();
    t_float_analog();
    t_sync();
    t_setclr();
    t_clr();
    t_readzero();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule